// File: doc/BRIEF.md
# Two-Wire DAC Channel Write Controller with Burst Loading

This block is the write side of a two-wire (I2C) slave that feeds a bank of DAC channel registers. It samples the bus clock and data lines with the system clock, finds START and STOP conditions and shifts in bytes. It acknowledges every byte it accepts by pulling the data line low during the ninth clock. Each accepted data word leaves the block as a one-cycle write strobe. The strobe carries the channel number, a two-bit register select and a 14-bit value.

A transaction opens with a 7-bit device address. Its upper five bits come from a parameter and its lower two from the address-select pins, and the R/W bit must be 0. In normal mode every write takes three bytes: a pointer byte whose low bits name the channel, then the high data byte, then the low data byte. A pointer byte of all ones starts burst loading instead. The channel pointer is set to 0, each following pair of data bytes writes the current channel, and the pointer then moves up by one. Once the last channel is written the block returns to three-byte mode. A STOP ends burst loading at any point.

Top module: `dac_i2c_wr_ctrl`

## Requirements
- R1: After reset, and while no transaction is active, the data-line pull-down is released and no write strobe is issued.
- R2: An address byte is acknowledged (pull-down active for the whole ninth clock) only when its upper seven bits equal {DEV_ADDR_HI, ad_i[1], ad_i[0]} and its bit 0 (R/W) is 0. Any other address byte receives no acknowledge.
- R3: After an address byte that is not acknowledged, the block acknowledges nothing and writes nothing until the next START.
- R4: In normal mode, a pointer byte other than 0xFF selects channel pointer[3:0]. The next two bytes form one write with wr_reg_o = first[7:6] and wr_data_o = {first[5:0], second}. Each of these bytes is acknowledged.
- R5: After a normal-mode write, the next byte in the same transaction is treated as a fresh pointer byte.
- R6: A pointer byte of 0xFF enters burst mode with the channel pointer at 0. From then on each pair of data bytes writes the current channel, and the pointer then increments by one.
- R7: After channel NUM_CH-1 has been written in burst mode, the block returns to normal mode, and the next byte is a pointer byte.
- R8: A STOP ends burst mode. The next transaction uses three-byte writes.
- R9: A START, including a repeated START, discards any partly received write and expects an address byte next.
- R10: Each write produces a strobe exactly one clock wide. The pull-down changes only just after a falling bus clock edge or a START or STOP.
- R11: In burst mode, every data byte is acknowledged, and no address or pointer byte is needed between channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (resolved wired-AND level) |
| ad_i | input | 2 | Low two bits of the device address |
| sda_oe_o | output | 1 | Pull data line low when 1 (acknowledge) |
| wr_o | output | 1 | One-cycle channel register write strobe |
| wr_ch_o | output | 4 | Channel written |
| wr_reg_o | output | 2 | Register select inside the channel |
| wr_data_o | output | 14 | Value written |

## Verification
The hardest states to reach are the two ways out of burst mode. One is the wrap after the final channel, which needs a full run of thirty-two data bytes in a single transaction. The other is a STOP arriving partway through the channel sequence. The bench drives a bit-level bus master through a complete sixteen-channel burst and then sends an ordinary pointer byte in the same transaction. It also runs a separate burst that it cuts short with a STOP and follows with a normal write. A repeated START placed between a pointer byte and its data shows that the partial write is discarded.

// File: rtl/dac_i2c_pkg.sv
package dac_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_MSB,
    ST_LSB
  } wr_state_e;

  localparam logic [7:0] BURST_PTR = 8'hFF;
endpackage

// File: rtl/dac_i2c_line_sync.sv
module dac_i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  // bus idles high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/dac_i2c_byte_rx.sv
module dac_i2c_byte_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       ack_take_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       sda_oe_o
);
  logic [2:0] bit_cnt;
  logic       active, in_ack, ack_clk, ack_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      sda_oe_o   <= 1'b0;
      bit_cnt    <= '0;
      active     <= 1'b0;
      in_ack     <= 1'b0;
      ack_clk    <= 1'b0;
      ack_pend   <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (start_i) begin
        active   <= 1'b1;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        ack_clk  <= 1'b0;
        ack_pend <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        active   <= 1'b0;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        ack_clk  <= 1'b0;
        ack_pend <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (active) begin
        if (scl_rise_i && !in_ack) begin
          byte_o <= {byte_o[6:0], sda_i};
          if (bit_cnt == 3'd7) begin
            byte_vld_o <= 1'b1;
            in_ack     <= 1'b1;
          end
          bit_cnt <= bit_cnt + 3'd1;
        end
        // decision from the decoder, valid while byte_vld_o is high
        if (byte_vld_o) ack_pend <= ack_take_i;
        if (scl_fall_i && in_ack) begin
          if (!ack_clk) begin
            ack_clk  <= 1'b1;
            sda_oe_o <= ack_pend;
          end else begin
            ack_clk  <= 1'b0;
            in_ack   <= 1'b0;
            sda_oe_o <= 1'b0;
            ack_pend <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dac_i2c_wr_fsm.sv
module dac_i2c_wr_fsm
  import dac_i2c_pkg::*;
#(
  parameter int          NUM_CH      = 16,
  parameter int          DATA_W      = 14,
  parameter logic [4:0]  DEV_ADDR_HI = 5'b10101,
  localparam int         CH_W        = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              byte_vld_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        ad_i,
  output logic              ack_take_o,
  output logic              wr_o,
  output logic [CH_W-1:0]   wr_ch_o,
  output logic [1:0]        wr_reg_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              burst_o,
  output wr_state_e         state_o
);
  localparam int HI_W = DATA_W - 8;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  wr_state_e       state_q;
  logic [CH_W-1:0] ch_q;
  logic [7:0]      msb_q;
  logic            burst_q;
  logic            addr_hit;

  assign addr_hit = (byte_i[7:1] == {DEV_ADDR_HI, ad_i}) && !byte_i[0];

  always_comb begin
    ack_take_o = 1'b0;
    if (byte_vld_i) begin
      unique case (state_q)
        ST_ADDR:                 ack_take_o = addr_hit;
        ST_PTR, ST_MSB, ST_LSB:  ack_take_o = 1'b1;
        default:                 ack_take_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ch_q      <= '0;
      msb_q     <= '0;
      burst_q   <= 1'b0;
      wr_o      <= 1'b0;
      wr_ch_o   <= '0;
      wr_reg_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        burst_q <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        burst_q <= 1'b0;
      end else if (byte_vld_i) begin
        unique case (state_q)
          ST_ADDR: state_q <= addr_hit ? ST_PTR : ST_IDLE;
          ST_PTR: begin
            state_q <= ST_MSB;
            if (byte_i == BURST_PTR) begin
              burst_q <= 1'b1;
              ch_q    <= '0;
            end else begin
              ch_q <= byte_i[CH_W-1:0];
            end
          end
          ST_MSB: begin
            msb_q   <= byte_i;
            state_q <= ST_LSB;
          end
          ST_LSB: begin
            wr_o      <= 1'b1;
            wr_ch_o   <= ch_q;
            wr_reg_o  <= msb_q[7:6];
            wr_data_o <= {msb_q[HI_W-1:0], byte_i};
            if (burst_q && ch_q != LAST_CH) begin
              ch_q    <= ch_q + 1'b1;
              state_q <= ST_MSB;
            end else begin
              burst_q <= 1'b0;
              state_q <= ST_PTR;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign burst_o = burst_q;
  assign state_o = state_q;
endmodule

// File: rtl/dac_i2c_wr_ctrl.sv
module dac_i2c_wr_ctrl
  import dac_i2c_pkg::*;
#(
  parameter int         NUM_CH      = 16,
  parameter int         DATA_W      = 14,
  parameter logic [4:0] DEV_ADDR_HI = 5'b10101,
  parameter int         SYNC_STAGES = 2,
  localparam int        CH_W        = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        ad_i,
  output logic              sda_oe_o,
  output logic              wr_o,
  output logic [CH_W-1:0]   wr_ch_o,
  output logic [1:0]        wr_reg_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rx_byte;
  logic       byte_vld, ack_take, burst;
  wr_state_e  state;

  dac_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  dac_i2c_byte_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .ack_take_i (ack_take),
    .byte_o     (rx_byte),
    .byte_vld_o (byte_vld),
    .sda_oe_o   (sda_oe_o)
  );

  dac_i2c_wr_fsm #(
    .NUM_CH      (NUM_CH),
    .DATA_W      (DATA_W),
    .DEV_ADDR_HI (DEV_ADDR_HI)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_i     (rx_byte),
    .byte_vld_i (byte_vld),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .ad_i       (ad_i),
    .ack_take_o (ack_take),
    .wr_o       (wr_o),
    .wr_ch_o    (wr_ch_o),
    .wr_reg_o   (wr_reg_o),
    .wr_data_o  (wr_data_o),
    .burst_o    (burst),
    .state_o    (state)
  );
endmodule

// File: rtl/dac_i2c_wr_sva.sv
module dac_i2c_wr_sva
  import dac_i2c_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      sda_oe_o,
  input logic      wr_o,
  input logic      scl_fall,
  input logic      start_det,
  input logic      stop_det,
  input logic      byte_vld,
  input logic      ack_take,
  input logic      burst,
  input wr_state_e state
);
  p_oe_moves_on_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  p_strobe_one_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);

  p_write_after_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(byte_vld));

  p_stop_ends_burst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !burst);

  p_start_wants_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state == ST_ADDR));

  p_ignored_no_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !ack_take);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state) == ST_IDLE) |-> !wr_o);
endmodule

bind dac_i2c_wr_ctrl dac_i2c_wr_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sda_oe_o  (sda_oe_o),
  .wr_o      (wr_o),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .byte_vld  (byte_vld),
  .ack_take  (ack_take),
  .burst     (burst),
  .state     (state)
);

// File: tb/dac_i2c_wr_ctrl_test.sv
module dac_i2c_wr_ctrl_test;
  localparam logic [4:0] ADDR_HI = 5'b10101;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] ad = 2'b01;
  logic sda_oe, wr;
  logic [3:0] wr_ch;
  logic [1:0] wr_reg;
  logic [13:0] wr_data;
  logic sda_line;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [19:0] exp_q[$];

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  dac_i2c_wr_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line), .ad_i(ad),
    .sda_oe_o(sda_oe), .wr_o(wr), .wr_ch_o(wr_ch), .wr_reg_o(wr_reg), .wr_data_o(wr_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr) begin
      logic [19:0] got, exp;
      got = {wr_ch, wr_reg, wr_data};
      if (exp_q.size() == 0) check(0, "R3/R4 unexpected write", int'(got), 0);
      else begin
        exp = exp_q.pop_front();
        check(got == exp, "R4/R6 write content", int'(got), int'(exp));
      end
      @(negedge clk);
      check(!wr, "R10 strobe width", int'(wr), 0);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b1; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit acked;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_clk(Q);
      m_scl = 1'b1; wait_clk(2 * Q);
      m_scl = 1'b0; wait_clk(Q);
    end
    m_sda = 1'b1; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    acked = !sda_line;
    wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q);
    check(acked == exp_ack, req, int'(acked), int'(exp_ack));
  endtask

  task automatic push_exp(input logic [3:0] ch, input logic [1:0] rg, input logic [13:0] d);
    exp_q.push_back({ch, rg, d});
  endtask

  task automatic send_pair(input logic [1:0] rg, input logic [13:0] d, input string req);
    send_byte({rg, d[13:8]}, 1'b1, req);
    send_byte(d[7:0], 1'b1, req);
  endtask

  task automatic normal_write(input logic [7:0] ptr, input logic [1:0] rg, input logic [13:0] d,
                              input string req);
    push_exp(ptr[3:0], rg, d);
    send_byte(ptr, 1'b1, req);
    send_pair(rg, d, req);
  endtask

  task automatic drain(input string req);
    wait_clk(20);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    check(sda_oe == 1'b0, "R1 reset pull-down", int'(sda_oe), 0);
    check(wr == 1'b0, "R1 reset strobe", int'(wr), 0);
    rst_n = 1'b1;
    wait_clk(10);
    check(sda_oe == 1'b0 && wr == 1'b0, "R1 idle after reset", int'({sda_oe, wr}), 0);

    // R2 / R4 / R5: two normal writes in one transaction
    i2c_start();
    send_byte({ADDR_HI, ad, 1'b0}, 1'b1, "R2 address ack");
    normal_write(8'h03, 2'b11, 14'h2A5C, "R4 normal write");
    normal_write(8'h3C, 2'b01, 14'h0001, "R5 next pointer");
    i2c_stop();
    drain("R4 writes seen");

    // R2: read bit set, not acknowledged
    i2c_start();
    send_byte({ADDR_HI, ad, 1'b1}, 1'b0, "R2 read nak");
    i2c_stop();

    // R3: wrong address, following bytes ignored
    i2c_start();
    send_byte({ADDR_HI ^ 5'b00100, ad, 1'b0}, 1'b0, "R2 mismatch nak");
    send_byte(8'h03, 1'b0, "R3 ignored ptr");
    send_byte(8'h40, 1'b0, "R3 ignored msb");
    send_byte(8'h55, 1'b0, "R3 ignored lsb");
    i2c_stop();
    drain("R3 no write");

    // R2: address pins take part in match
    ad = 2'b10;
    wait_clk(5);
    i2c_start();
    send_byte({ADDR_HI, 2'b01, 1'b0}, 1'b0, "R2 old pins nak");
    i2c_stop();
    i2c_start();
    send_byte({ADDR_HI, 2'b10, 1'b0}, 1'b1, "R2 new pins ack");
    normal_write(8'h0A, 2'b10, 14'h3FFF, "R4 pins write");
    i2c_stop();
    drain("R2 pins write seen");

    // R6 / R7 / R11: full burst then fallback pointer
    i2c_start();
    send_byte({ADDR_HI, ad, 1'b0}, 1'b1, "R2 burst addr");
    send_byte(8'hFF, 1'b1, "R6 burst pointer ack");
    for (int c = 0; c < 16; c++) begin
      logic [13:0] d;
      d = 14'((c * 14'h0111) ^ 14'h1234);
      push_exp(4'(c), 2'(c), d);
      send_pair(2'(c), d, "R11 burst data ack");
    end
    normal_write(8'h05, 2'b00, 14'h0ABC, "R7 fallback pointer");
    i2c_stop();
    drain("R6 burst writes seen");

    // R8: STOP cuts burst short
    i2c_start();
    send_byte({ADDR_HI, ad, 1'b0}, 1'b1, "R2 addr");
    send_byte(8'hFF, 1'b1, "R6 burst pointer ack");
    for (int c = 0; c < 3; c++) begin
      push_exp(4'(c), 2'b01, 14'(c + 7));
      send_pair(2'b01, 14'(c + 7), "R11 burst data ack");
    end
    i2c_stop();
    i2c_start();
    send_byte({ADDR_HI, ad, 1'b0}, 1'b1, "R2 addr");
    normal_write(8'h07, 2'b10, 14'h1357, "R8 normal after stop");
    i2c_stop();
    drain("R8 writes seen");

    // R9: repeated START discards partial write
    i2c_start();
    send_byte({ADDR_HI, ad, 1'b0}, 1'b1, "R2 addr");
    send_byte(8'h02, 1'b1, "R4 ptr ack");
    send_byte(8'h80, 1'b1, "R4 msb ack");
    i2c_start();
    send_byte({ADDR_HI, ad, 1'b0}, 1'b1, "R9 addr after Sr");
    normal_write(8'h09, 2'b00, 14'h2468, "R9 write after Sr");
    i2c_stop();
    drain("R9 only new write");
    check(sda_oe == 1'b0, "R1 released at end", int'(sda_oe), 0);

    done = 1;
    report();
    $finish;
  end
endmodule